// File: doc/BRIEF.md
# Serial Elastic Store with Pointer Initialization

This block absorbs the rate difference between a serial bit stream that arrives on its own bit clock and a local system clock. Each incoming bit is written into a 16-location single-bit store at the position given by a write counter that runs on the incoming clock. A read counter in the local domain advances on a gated enable. Its value is registered into a holding register, and that register addresses the store. The selected bit is then reclocked into an output flop.

To keep the two pointers apart, an initialization sequence runs at a fixed slot in the local frame, bit 0 of word 24. It first clears the read counter. Two local clocks later it sends a preset request across to the write side, which forces the write counter to 10. Once the crossing latency has been absorbed, the pointers sit about eight locations apart, so a read never lands on the location being written. One initialization is armed by power-up reset. Each later one is armed by an out-of-tolerance pulse from the rate-compare logic outside the block. That logic also receives the write pointer, which this block brings into the local domain through a Gray-coded two-flop synchronizer.

Top module: `serial_elastic_store`

## Requirements
- R1: The store holds 16 one-bit locations. On each rising `wr_clk` edge, `wr_bit` is written at the current write address, and the 4-bit write counter then advances by one, wrapping from 15 to 0.
- R2: On each `sys_clk` edge where `rd_en` is high and no initialization fires, the read counter advances by one and wraps modulo 16. When `rd_en` is low, it holds.
- R3: `rd_addr` is the holding register. It shows the read counter value from one `sys_clk` edge earlier.
- R4: On every `sys_clk` edge, `dout` takes the stored bit at the location currently shown on `rd_addr`. A bit at location k therefore appears on `dout` one edge after `rd_addr` shows k.
- R5: An initialization fires on a `sys_clk` edge only when a request is armed, no initialization is in progress, `word_idx` equals 24 and `bit_idx` equals 0. At that edge the read counter becomes 0 and `init_busy` goes high. Any other word or bit value leaves the pointers untouched.
- R6: Two `sys_clk` edges after the firing edge, a preset request is issued and `init_busy` drops. The third `wr_clk` edge after that request writes its bit at location 10 and leaves the write counter at 11.
- R7: Power-up reset arms one request, and a high `oot` on any edge arms another. Firing disarms the request. If the request is not armed, word 24 / bit 0 has no effect.
- R8: `wr_addr_sys` is the write counter carried into the `sys_clk` domain as Gray code through two flops and decoded to binary. It equals the write counter once `wr_clk` has been idle for three `sys_clk` cycles.
- R9: While `rst_n` is low, `dout`, `rd_addr`, `wr_addr_sys` and `init_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| wr_clk | input | 1 | Incoming bit clock; one bit is written per rising edge |
| wr_bit | input | 1 | Serial data bit sampled on `wr_clk` |
| sys_clk | input | 1 | Local system clock |
| rd_en | input | 1 | Gated read enable; advances the read counter |
| word_idx | input | WORD_W (5) | Current frame word index in the local frame |
| bit_idx | input | BIT_W (3) | Current bit index within the word |
| oot | input | 1 | Out-of-tolerance pulse; arms a re-initialization |
| dout | output | 1 | Reclocked serial output |
| rd_addr | output | AW (4) | Holding-register read address |
| wr_addr_sys | output | AW (4) | Write pointer synchronized into the `sys_clk` domain |
| init_busy | output | 1 | High from the firing edge until the preset request goes out |

## Verification
The embedded assertions check the step-by-step rules on every cycle:
- the read counter step and hold;
- the holding register tracking the counter;
- the read counter clearing at the firing edge and firing only at word 24 / bit 0;
- the preset toggle when the delay expires;
- the write counter step and its forced value of 11 after a preset.

Only the bench scenarios can show the end-to-end results. These are:
- the bits written from location 10 onward coming back out in order;
- a disarmed word 24 being ignored;
- an out-of-tolerance pulse re-arming the sequence;
- the synchronized write pointer settling to the expected count.

// File: rtl/serial_elastic_store.sv
module serial_elastic_store #(
  parameter int AW           = 4,
  parameter int WORD_W       = 5,
  parameter int BIT_W        = 3,
  parameter int INIT_WORD    = 24,
  parameter int WR_PRESET    = 10,
  parameter int PRESET_DELAY = 2
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_bit,
  input  logic              sys_clk,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              oot,
  output logic              dout,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr_sys,
  output logic              init_busy
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = $clog2(PRESET_DELAY + 1);

  function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW-1:0] from_gray(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] store;

  // write domain
  logic [AW-1:0] wr_cnt, wr_gray, wr_at, wr_nxt;
  logic [2:0]    pre_sync;
  logic          wr_load;
  logic          preset_tgl;

  assign wr_load = pre_sync[1] ^ pre_sync[2];
  assign wr_at   = wr_load ? AW'(WR_PRESET) : wr_cnt;
  assign wr_nxt  = wr_at + AW'(1);

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wr_cnt   <= '0;
      wr_gray  <= '0;
      pre_sync <= '0;
    end else begin
      wr_cnt   <= wr_nxt;
      wr_gray  <= to_gray(wr_nxt);
      pre_sync <= {pre_sync[1:0], preset_tgl};
    end

  always_ff @(posedge wr_clk) store[wr_at] <= wr_bit;

  // system domain
  logic [AW-1:0] g_s1, g_s2, rd_cnt, rd_hold;
  logic [DW-1:0] dly;
  logic          armed, init_fire;

  assign init_busy   = (dly != '0);
  assign init_fire   = armed && !init_busy && (word_idx == WORD_W'(INIT_WORD)) && (bit_idx == '0);
  assign wr_addr_sys = from_gray(g_s2);
  assign rd_addr     = rd_hold;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      g_s1 <= '0;
      g_s2 <= '0;
    end else begin
      g_s1 <= wr_gray;
      g_s2 <= g_s1;
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      armed      <= 1'b1;
      dly        <= '0;
      preset_tgl <= 1'b0;
    end else begin
      if (oot)            armed <= 1'b1;
      else if (init_fire) armed <= 1'b0;
      if (init_fire)      dly <= DW'(PRESET_DELAY);
      else if (init_busy) dly <= dly - DW'(1);
      if (dly == DW'(1))  preset_tgl <= ~preset_tgl;
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      rd_cnt  <= '0;
      rd_hold <= '0;
      dout    <= 1'b0;
    end else begin
      if (init_fire)  rd_cnt <= '0;
      else if (rd_en) rd_cnt <= rd_cnt + AW'(1);
      rd_hold <= rd_cnt;
      dout    <= store[rd_hold];
    end

  a_r1_wr_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_load |=> wr_cnt == $past(wr_cnt) + AW'(1));

  a_r6_preset_load: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_load |=> wr_cnt == AW'(WR_PRESET + 1));

  a_r2_rd_step: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (rd_en && !init_fire) |=> rd_cnt == $past(rd_cnt) + AW'(1));

  a_r2_rd_hold: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!rd_en && !init_fire) |=> $stable(rd_cnt));

  a_r3_hold_tracks: assert property (@(posedge sys_clk) disable iff (!rst_n)
    1'b1 |=> rd_addr == $past(rd_cnt));

  a_r5_rd_clear: assert property (@(posedge sys_clk) disable iff (!rst_n)
    init_fire |=> rd_cnt == '0 && init_busy);

  a_r5_slot_only: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(armed) |-> $past(word_idx) == WORD_W'(INIT_WORD) && $past(bit_idx) == '0);

  a_r6_preset_issue: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (dly == DW'(1)) |=> preset_tgl != $past(preset_tgl) && !init_busy);

endmodule

// File: tb/serial_elastic_store_tb.sv
module serial_elastic_store_tb_top;
  logic       rst_n = 1'b0, wr_clk = 1'b0, wr_bit = 1'b0, clk = 1'b0;
  logic       rd_en = 1'b0, oot = 1'b0;
  logic [4:0] word_idx = '0;
  logic [2:0] bit_idx = '0;
  logic       dout, init_busy;
  logic [3:0] rd_addr, wr_addr_sys;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // {data bit, expected store location}
  localparam logic [4:0] VEC [12] = '{5'h1A, 5'h0B, 5'h1C, 5'h1D, 5'h0E, 5'h0F,
                                      5'h10, 5'h01, 5'h12, 5'h13, 5'h14, 5'h05};
  logic exp_v [16];
  bit   exp_w [16];

  serial_elastic_store dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_bit(wr_bit), .sys_clk(clk), .rd_en(rd_en),
    .word_idx(word_idx), .bit_idx(bit_idx), .oot(oot), .dout(dout), .rd_addr(rd_addr),
    .wr_addr_sys(wr_addr_sys), .init_busy(init_busy));

  always #2.5 clk = ~clk;

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wpulse(input logic b);
    wr_bit = b; #2; wr_clk = 1'b1; #3; wr_clk = 1'b0; #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (exp_w[i]) begin exp_w[i] = 0; exp_v[i] = 1'b0; end
    repeat (3) tick;
    check("R9 dout", dout, 0);
    check("R9 rd_addr", rd_addr, 0);
    check("R9 wr_addr_sys", wr_addr_sys, 0);
    check("R9 init_busy", init_busy, 0);
    rst_n = 1'b1;
    tick;

    word_idx = 5'd3; rd_en = 1'b1;
    repeat (3) tick;
    check("R3 rd_addr lag", rd_addr, 2);
    check("R5 no fire off slot", init_busy, 0);
    rd_en = 1'b0;
    tick;
    check("R2 rd_addr after advance", rd_addr, 3);
    tick;
    check("R2 hold without enable", rd_addr, 3);

    word_idx = 5'd24; bit_idx = 3'd3;
    tick;
    check("R5 bit must be 0", init_busy, 0);
    bit_idx = 3'd0;
    tick;
    word_idx = 5'd0;
    check("R5 busy on fire", init_busy, 1);
    tick;
    check("R5 read reset", rd_addr, 0);
    check("R6 busy one edge later", init_busy, 1);
    tick;
    check("R6 busy drops after two", init_busy, 0);

    wpulse(1'b0);
    wpulse(1'b1);
    for (int i = 0; i < 12; i++) begin
      wpulse(VEC[i][4]);
      exp_v[VEC[i][3:0]] = VEC[i][4];
      exp_w[VEC[i][3:0]] = 1;
    end
    repeat (4) tick;
    check("R8 R6 synced write pointer", wr_addr_sys, 6);

    rd_en = 1'b1;
    for (int k = 1; k <= 17; k++) begin
      tick;
      if (k >= 2 && exp_w[k-2]) check("R4 R1 R6 read data", dout, exp_v[k-2]);
      if (k == 5) check("R3 rd_addr during read", rd_addr, 4);
    end
    rd_en = 1'b0;
    tick;
    check("R2 wrap", rd_addr, 1);

    word_idx = 5'd24; bit_idx = 3'd0;
    tick;
    word_idx = 5'd0;
    check("R7 disarmed slot busy", init_busy, 0);
    tick;
    check("R7 disarmed slot rd_addr", rd_addr, 1);

    oot = 1'b1;
    tick;
    oot = 1'b0;
    check("R7 oot alone no fire", init_busy, 0);
    repeat (2) tick;
    check("R7 oot waits for slot", rd_addr, 1);
    word_idx = 5'd24;
    tick;
    word_idx = 5'd0;
    check("R7 re-init busy", init_busy, 1);
    tick;
    check("R7 re-init read reset", rd_addr, 0);
    tick;
    wpulse(1'b1);
    wpulse(1'b1);
    wpulse(1'b0);
    repeat (4) tick;
    check("R6 re-preset write pointer", wr_addr_sys, 11);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule